// File: doc/BRIEF.md
# Serial SAR Converter Readout Controller

This block sits on the host side of a 14-bit successive-approximation converter that returns its results over a three-wire serial link. It runs entirely on the system clock. On a request it drives the active-low conversion-start strobe and, in the sync-framed mode, an active-low frame-sync line. It oversamples the serial clock and data that come back from the converter, and it assembles each 16-bit frame into a parallel result.

A frame carries an overrange flag, then the 14-bit straight-binary code with the most significant bit first, then one guard bit that must read zero. The converter returns each word one sample late: the frame read during conversion N holds the result of conversion N-1. The controller therefore drops the first frame after reset and reports every later frame as the result of the previous request.

A static select input picks the framing. With select 0 the start strobe stays low for the whole frame and frames the data, while frame sync is held low. With select 1 the strobe is a short pulse that only starts the conversion, and frame sync is driven low around the data.

Top module: `adcr_ctrl`

## Requirements
- R1: After reset, `conv_start_n` is 1, `frame_sync_n` is 0, and `res_valid`, `res_ovr`, `res_ferr` and `res_code` are all 0.
- R2: With select 0, `conv_start_n` falls and then stays low for exactly FRAME_PULSES (22) falling edges of `ser_clk` before it returns high, and `frame_sync_n` stays low throughout.
- R3: With select 1, `conv_start_n` goes low for exactly STRB_CYC (2) system cycles. Afterwards `frame_sync_n` goes low for exactly FRAME_PULSES falling edges of `ser_clk`, and `conv_start_n` stays high while it is low.
- R4: Bits are taken on falling `ser_clk` edges after framing starts. The first bit goes to `res_ovr`, the next 14 go to `res_code` MSB first, and the 16th is the guard bit. Later pulses are ignored.
- R5: The first completed frame after reset gives no `res_valid`. Every later frame gives exactly one pulse, and its values are those the converter sampled at the previous request.
- R6: `res_ferr` is updated only together with `res_valid` and is 1 exactly when the guard bit of that frame was 1.
- R7: `frame_sel` is sampled only when a request is accepted in idle. Changing it during a conversion does not alter the framing lines of that conversion.
- R8: A request raised while a conversion is in progress is ignored. It starts no strobe and gives no extra `res_valid`.
- R9: `res_valid` is high for a single cycle, and `res_code`, `res_ovr` and `res_ferr` hold their values until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| conv_req | input | 1 | Request one conversion; taken only while idle |
| frame_sel | input | 1 | Framing select: 0 strobe-framed, 1 sync-framed |
| ser_clk | input | 1 | Serial bit clock from the converter |
| ser_data | input | 1 | Serial data from the converter, changes on rising `ser_clk` |
| conv_start_n | output | 1 | Active-low conversion-start strobe |
| frame_sync_n | output | 1 | Active-low frame sync toward the converter |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_code | output | CODE_W (14) | Straight-binary conversion code |
| res_ovr | output | 1 | Overrange flag of the result |
| res_ferr | output | 1 | Guard bit of the frame was nonzero |

## Verification
Two events can meet at the end of a frame. The result is published from the done state at the same time as the controller becomes ready for the next request, and a stray request can arrive while a frame is still being counted. The bench issues back-to-back requests right after each pulse, raises an extra request in the middle of a frame, and flips `frame_sel` in the middle of a strobe-framed frame. It then checks that each frame produces exactly one valid pulse carrying the previous sample, that the framing lines keep their mode, and that no extra strobe follows the ignored request.

// File: rtl/adcr_pkg.sv
package adcr_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_STRB  = 3'd1,
    S_WAIT  = 3'd2,
    S_FRAME = 3'd3,
    S_DONE  = 3'd4
  } seq_st_t;
endpackage

// File: rtl/adcr_sync.sv
// Brings the serial clock and data into the system domain through matched
// pipelines and flags a falling edge of the serial clock.
module adcr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic sdat_i,
  output logic fall_o,
  output logic sdat_o
);
  logic [STAGES:0]   ck_pipe;
  logic [STAGES-1:0] dt_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_pipe <= '0;
      dt_pipe <= '0;
    end else begin
      ck_pipe <= {ck_pipe[STAGES-1:0], sclk_i};
      dt_pipe <= {dt_pipe[STAGES-2:0], sdat_i};
    end
  end

  // newest synchronized sample is index STAGES-1 in both pipes
  assign fall_o = ck_pipe[STAGES] & ~ck_pipe[STAGES-1];
  assign sdat_o = dt_pipe[STAGES-1];
endmodule

// File: rtl/adcr_shift.sv
// Frame assembly register, shifting left so the first bit lands on top.
module adcr_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         din_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] word_q;
  logic [W-1:0] word_d;
  logic         word_en;

  always_comb begin
    word_en = clr_i | en_i;
    word_d  = clr_i ? '0 : {word_q[W-2:0], din_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  assign word_o = word_q;
endmodule

// File: rtl/adcr_seq.sv
module adcr_seq
  import adcr_pkg::*;
#(
  parameter int CODE_W       = 14,
  parameter int FRAME_PULSES = 22,
  parameter int STRB_CYC     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_i,
  input  logic                mode_i,
  input  logic                fall_i,
  input  logic [CODE_W+1:0]   word_i,
  output logic                convst_n_o,
  output logic                tfs_n_o,
  output logic                shift_clr_o,
  output logic                shift_en_o,
  output logic                valid_o,
  output logic [CODE_W-1:0]   code_o,
  output logic                ovr_o,
  output logic                ferr_o,
  output seq_st_t             state_o,
  output logic                mode_o
);
  localparam int FW   = CODE_W + 2;
  localparam int CMAX = (FRAME_PULSES > STRB_CYC) ? FRAME_PULSES : STRB_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  seq_st_t           st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              mode_q, mode_ld;
  logic              primed_q, primed_d;
  logic              valid_q, valid_d;
  logic              res_ld;
  logic [CODE_W-1:0] code_q;
  logic              ovr_q, ferr_q;

  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    mode_ld     = 1'b0;
    shift_clr_o = 1'b0;
    shift_en_o  = 1'b0;
    valid_d     = 1'b0;
    res_ld      = 1'b0;
    primed_d    = primed_q;
    unique case (st_q)
      S_IDLE: begin
        if (req_i) begin
          mode_ld     = 1'b1;
          shift_clr_o = 1'b1;
          cnt_d       = '0;
          st_d        = mode_i ? S_STRB : S_WAIT;
        end
      end
      S_STRB: begin
        if (cnt_q == CW'(STRB_CYC - 1)) begin
          cnt_d = '0;
          st_d  = S_WAIT;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_WAIT: begin
        if (fall_i) begin
          cnt_d = '0;
          st_d  = S_FRAME;
        end
      end
      S_FRAME: begin
        if (fall_i) begin
          shift_en_o = (cnt_q < CW'(FW));
          if (cnt_q == CW'(FRAME_PULSES - 1)) begin
            cnt_d = '0;
            st_d  = S_DONE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      S_DONE: begin
        valid_d  = primed_q;
        res_ld   = primed_q;
        primed_d = 1'b1;
        st_d     = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      cnt_q    <= '0;
      mode_q   <= 1'b0;
      primed_q <= 1'b0;
      valid_q  <= 1'b0;
      code_q   <= '0;
      ovr_q    <= 1'b0;
      ferr_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      primed_q <= primed_d;
      valid_q  <= valid_d;
      if (mode_ld) mode_q <= mode_i;
      if (res_ld) begin
        ovr_q  <= word_i[FW-1];
        code_q <= word_i[FW-2:1];
        ferr_q <= word_i[0];
      end
    end
  end

  assign convst_n_o = ~((st_q == S_STRB) | ((st_q == S_FRAME) & ~mode_q));
  assign tfs_n_o    = mode_q ? ~(st_q == S_FRAME) : 1'b0;
  assign valid_o    = valid_q;
  assign code_o     = code_q;
  assign ovr_o      = ovr_q;
  assign ferr_o     = ferr_q;
  assign state_o    = st_q;
  assign mode_o     = mode_q;
endmodule

// File: rtl/adcr_ctrl.sv
module adcr_ctrl
  import adcr_pkg::*;
#(
  parameter int CODE_W       = 14,
  parameter int FRAME_PULSES = 22,
  parameter int STRB_CYC     = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_req,
  input  logic              frame_sel,
  input  logic              ser_clk,
  input  logic              ser_data,
  output logic              conv_start_n,
  output logic              frame_sync_n,
  output logic              res_valid,
  output logic [CODE_W-1:0] res_code,
  output logic              res_ovr,
  output logic              res_ferr
);
  localparam int FW = CODE_W + 2;

  logic [1:0]    rst_pipe;
  logic          rst_int_n;
  logic          fall_evt;
  logic          sdat_s;
  logic          sh_clr;
  logic          sh_en;
  logic [FW-1:0] frame_word;
  seq_st_t       seq_state;
  logic          seq_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  adcr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .sclk_i (ser_clk),
    .sdat_i (ser_data),
    .fall_o (fall_evt),
    .sdat_o (sdat_s)
  );

  adcr_shift #(.W(FW)) u_shift (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr_i  (sh_clr),
    .en_i   (sh_en),
    .din_i  (sdat_s),
    .word_o (frame_word)
  );

  adcr_seq #(
    .CODE_W       (CODE_W),
    .FRAME_PULSES (FRAME_PULSES),
    .STRB_CYC     (STRB_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_i       (conv_req),
    .mode_i      (frame_sel),
    .fall_i      (fall_evt),
    .word_i      (frame_word),
    .convst_n_o  (conv_start_n),
    .tfs_n_o     (frame_sync_n),
    .shift_clr_o (sh_clr),
    .shift_en_o  (sh_en),
    .valid_o     (res_valid),
    .code_o      (res_code),
    .ovr_o       (res_ovr),
    .ferr_o      (res_ferr),
    .state_o     (seq_state),
    .mode_o      (seq_mode)
  );
endmodule

// File: rtl/adcr_chk.sv
module adcr_chk
  import adcr_pkg::*;
#(
  parameter int STRB_CYC = 2
) (
  input logic    clk,
  input logic    rst_n,
  input logic    conv_start_n,
  input logic    frame_sync_n,
  input logic    res_valid,
  input logic    res_ferr,
  input seq_st_t seq_state,
  input logic    seq_mode
);
  localparam int RW = $clog2(STRB_CYC + 2);
  logic [RW-1:0] strb_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  strb_run <= '0;
    else if (seq_state == S_STRB) strb_run <= strb_run + 1'b1;
    else                         strb_run <= '0;
  end

  // R9: a result pulse lasts one cycle
  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R5: a pulse only follows the end of a frame
  a_r5_valid_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(seq_state) == S_DONE);

  // R6: error flag moves only with a result pulse
  a_r6_ferr_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_ferr));

  // R7: selected framing is frozen outside idle
  a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state != S_IDLE) |=> $stable(seq_mode));

  // R3: strobe and frame sync never low together in sync-framed mode
  a_r3_sync_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && !frame_sync_n) |-> conv_start_n);

  // R3: strobe pulse no longer than STRB_CYC cycles
  a_r3_strobe_len: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == S_STRB) |-> (strb_run < RW'(STRB_CYC)));

  // R2: frame sync held low in strobe-framed mode
  a_r2_sync_low: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_mode |-> !frame_sync_n);
endmodule

bind adcr_ctrl adcr_chk #(.STRB_CYC(STRB_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .conv_start_n (conv_start_n),
  .frame_sync_n (frame_sync_n),
  .res_valid    (res_valid),
  .res_ferr     (res_ferr),
  .seq_state    (seq_state),
  .seq_mode     (seq_mode)
);

// File: tb/sim_adcr_ctrl.sv
`timescale 1ns/1ps
module sim_adcr_ctrl;
  localparam int CODE_W = 14;
  localparam int PULSES = 22;
  localparam int STRB   = 2;
  localparam int NCONV  = 32;
  localparam int HALF   = 5;

  logic clk, rst_n, conv_req, frame_sel, ser_clk, ser_data;
  logic conv_start_n, frame_sync_n, res_valid, res_ovr, res_ferr;
  logic [CODE_W-1:0] res_code;

  int checks = 0;
  int errors = 0;
  int vcount = 0;
  int wide   = 0;
  int fr_falls = 0;
  logic prev_v = 1'b0;
  logic [CODE_W-1:0] last_code;
  logic last_ovr, last_ferr;
  logic m_mode = 1'b0;
  logic [15:0] pending = '0;
  logic [15:0] held = '0;
  logic [15:0] out_frame = '0;
  bit done = 0;

  adcr_ctrl #(.CODE_W(CODE_W), .FRAME_PULSES(PULSES), .STRB_CYC(STRB)) u0 (
    .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .frame_sel(frame_sel),
    .ser_clk(ser_clk), .ser_data(ser_data), .conv_start_n(conv_start_n),
    .frame_sync_n(frame_sync_n), .res_valid(res_valid), .res_code(res_code),
    .res_ovr(res_ovr), .res_ferr(res_ferr));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic framed();
    return m_mode ? !frame_sync_n : !conv_start_n;
  endfunction

  // sample k as {ovr, code, guard}
  function automatic logic [15:0] sample(input int k);
    logic [CODE_W-1:0] c;
    if (k < 14)      c = CODE_W'(1) << k;
    else if (k < 28) c = ~(CODE_W'(1) << (k - 14));
    else             c = CODE_W'((k * 2897 + 113) % 16384);
    return {(k % 4 == 3), c, (k % 7 == 5)};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // converter model: serial clock, data on rising edge, latency of one sample
  initial begin
    int idx = 0;
    ser_clk = 1'b0;
    ser_data = 1'b0;
    forever begin
      repeat (HALF) @(negedge clk);
      ser_clk = ~ser_clk;
      if (ser_clk) begin
        if (framed()) begin
          ser_data = (idx < 16) ? out_frame[15 - idx] : 1'b0;
          idx++;
        end else begin
          idx = 0;
          ser_data = 1'b0;
        end
      end else if (framed()) begin
        fr_falls++;
      end
    end
  end

  initial begin
    forever begin
      @(negedge conv_start_n);
      out_frame = held;
      held = pending;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (res_valid) begin
        vcount++;
        last_code = res_code;
        last_ovr  = res_ovr;
        last_ferr = res_ferr;
        if (prev_v) wide++;
      end
      prev_v = res_valid;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_conv(input int k);
    int n, sync_hi, v0;
    logic [15:0] exp_w;
    m_mode = k[0];
    frame_sel = k[0];
    pending = sample(k);
    fr_falls = 0;
    v0 = vcount;
    @(negedge clk) conv_req = 1'b1;
    @(negedge clk) conv_req = 1'b0;
    if (m_mode) begin
      n = 0;
      while (!conv_start_n) begin n++; @(negedge clk); end
      chk("R3 strobe cycles", n, STRB);
    end
    while (!framed()) @(negedge clk);
    n = 0;
    sync_hi = 0;
    while (framed()) begin
      n++;
      if (!m_mode && frame_sync_n) sync_hi++;
      if (m_mode && !conv_start_n) sync_hi++;
      if (n == 40 && k == 10) frame_sel = ~frame_sel;
      if (n == 40 && k == 12) conv_req = 1'b1;
      if (n == 41) conv_req = 1'b0;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    if (m_mode) chk("R3 falls under frame sync", fr_falls, PULSES);
    else        chk("R2 falls under strobe", fr_falls, PULSES);
    if (k == 10) chk("R7 frame sync held low after select flip", sync_hi, 0);
    else         chk("R2/R3 other framing line idle", sync_hi, 0);
    chk("R5 pulses for this frame", vcount - v0, (k > 0) ? 1 : 0);
    if (k > 0) begin
      exp_w = sample(k - 1);
      chk("R4 code", int'(last_code), int'(exp_w[14:1]));
      chk("R4 ovr", int'(last_ovr), int'(exp_w[15]));
      chk("R6 guard error", int'(last_ferr), int'(exp_w[0]));
      chk("R9 code held", int'(res_code), int'(exp_w[14:1]));
    end
    if (k == 12) begin
      n = 0;
      repeat (40) begin @(negedge clk); if (!conv_start_n) n++; end
      chk("R8 no strobe from busy request", n, 0);
      chk("R8 no extra pulse", vcount - v0, 1);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    conv_req = 1'b0;
    frame_sel = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 strobe", int'(conv_start_n), 1);
    chk("R1 frame sync", int'(frame_sync_n), 0);
    chk("R1 valid", int'(res_valid), 0);
    chk("R1 code", int'(res_code), 0);
    chk("R1 ovr", int'(res_ovr), 0);
    chk("R1 ferr", int'(res_ferr), 0);
    for (int k = 0; k < NCONV; k++) run_conv(k);
    chk("R9 pulse width", wide, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule